// File: doc/BRIEF.md
# Character-Synchronous Transmit Sequencer with Underrun Fill

This block is the transmit engine of a byte-oriented synchronous serial channel that runs in either single-sync or double-sync framing. It takes message bytes from a valid/ready stream and sends them one bit per transmit-clock enable, least significant bit first. While a message is being sent it computes a CRC-CCITT over the bytes. A message ends in one of two ways. Either the stream runs dry at a character boundary (an underrun), or the number of bytes sent reaches a programmed length limit. When a message ends, the block sends a programmable fill sequence. That sequence can append the CRC and can use one or both sync characters. The block then idles on the second sync character until new data arrives.

Back-pressure rules for the input stream: `in_ready` is high for a single cycle at each character boundary where the sequencer may take a byte. That is the case while it idles, and while it is inside a message that is still below its limit. `in_ready` never depends on `in_valid`. A byte is taken only in a cycle where both are high. If `in_valid` is low in that cycle, the sequencer does not wait. It commits to fill, or to idle sync, for a full character. The source may hold `in_valid` and `in_data` for as long as it likes.

Top module: `csync_tx`

## Requirements
- R1: Each character takes 8 consecutive `bit_en` cycles. `txd` changes only on a clock edge where `bit_en` is high. After reset `txd` is 1 until the first enable.
- R2: `in_ready` is high only in a cycle where `bit_en` is high and the current character is on its last bit. In that cycle the sequencer must also be either idling or inside a message below its limit. A byte is transferred when `in_valid` and `in_ready` are both high.
- R3: The CRC is CRC-CCITT (polynomial 0x1021). It is preset to 0xFFFF at the first byte of each message and updated over the data bits in the order they are sent. When the CRC is sent, it goes out bit 15 first, down to bit 0.
- R4: With `msg_limit` nonzero, the sequencer takes exactly `msg_limit` bytes and then starts the fill sequence, even if more data is waiting. A `msg_limit` of 0 means no limit.
- R5: With `fill_policy` = 00, the end of a message is followed by `syn1`, repeated.
- R6: With `fill_policy` = 01, the end of a message is followed by `syn0` and then `syn1` when `bisync_mode` = 1. When `bisync_mode` = 0, it is followed by `syn1` only.
- R7: With `fill_policy` = 10, the end of a message is followed by the CRC and then `syn1`.
- R8: With `fill_policy` = 11, the end of a message is followed by the CRC, `syn0` and `syn1` when `bisync_mode` = 1. When `bisync_mode` = 0, it is followed by the CRC and `syn1`.
- R9: When idling, with no valid data at a boundary, the sequencer sends `syn1`. This includes the time right after reset. A new message starts at the first boundary after the fill's `syn1` where `in_valid` is high.
- R10: `underrun_flag` resets to 0. It is set when a message finds no data at a boundary before reaching its limit, and it is not set when a message ends on its limit. It stays set until `underrun_clr` is pulsed. A new set wins over a clear in the same cycle.
- R11: `msg_active` is high exactly while a data character is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Transmit bit enable, one bit per high cycle |
| bisync_mode | input | 1 | 0 = single sync character, 1 = two sync characters |
| fill_policy | input | 2 | Selects the fill sequence at end of message |
| syn0 | input | 8 | First sync character |
| syn1 | input | 8 | Second sync character, the idle character |
| msg_limit | input | CNT_W | Bytes per message, 0 = unlimited |
| underrun_clr | input | 1 | Write-one-to-clear for the underrun flag |
| in_data | input | 8 | Stream data byte |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Sequencer takes a byte this cycle if valid |
| txd | output | 1 | Serial data out |
| msg_active | output | 1 | A data character is on the line |
| underrun_flag | output | 1 | Sticky underrun status |

## Verification
The assertions assume the following about the inputs. `fill_policy`, `bisync_mode`, the sync characters and `msg_limit` are held constant while a message or its fill is in progress. `underrun_clr` is a plain level. The stimulus meets this by programming each configuration during reset and only then releasing the data. The bench sweeps both framing modes, all four fill policies, and three message shapes: an underrun after an idle lead-in, a limit reached with data still waiting, and a limit reached exactly as the data runs out. Enable patterns are either dense or sparse. It compares the whole serial stream against a bit sequence it builds arithmetically.

// File: rtl/csync_pkg.sv
package csync_pkg;
  localparam int CHAR_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY   = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_SYN0, ST_CRCH, ST_CRCL
  } tx_state_e;

  // CRC over one character, bits taken in transmit order (LSB first)
  function automatic logic [CRC_W-1:0] crc_char(input logic [CRC_W-1:0] c,
                                                input logic [CHAR_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < CHAR_W; i++) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic logic [CHAR_W-1:0] rev_char(input logic [CHAR_W-1:0] d);
    logic [CHAR_W-1:0] r;
    for (int i = 0; i < CHAR_W; i++) r[i] = d[CHAR_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/csync_crc16.sv
module csync_crc16
  import csync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [CHAR_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= CRC_PRESET;
    else if (start) crc <= crc_char(CRC_PRESET, data);
    else if (step)  crc <= crc_char(crc, data);
  end
endmodule

// File: rtl/csync_shift.sv
module csync_shift #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [CHAR_W-1:0] load_val,
  output logic              boundary,
  output logic              txd
);
  localparam int BC_W = $clog2(CHAR_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(CHAR_W - 1);

  logic [CHAR_W-1:0] sh_q;
  logic [BC_W-1:0]   bc_q;

  assign boundary = bit_en && (bc_q == LAST);
  assign txd      = sh_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
      bc_q <= LAST;
    end else if (bit_en) begin
      if (bc_q == LAST) begin
        sh_q <= load_val;
        bc_q <= '0;
      end else begin
        sh_q <= {1'b1, sh_q[CHAR_W-1:1]};
        bc_q <= bc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csync_tx.sv
module csync_tx
  import csync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bisync_mode,
  input  logic [1:0]        fill_policy,
  input  logic [CHAR_W-1:0] syn0,
  input  logic [CHAR_W-1:0] syn1,
  input  logic [CNT_W-1:0]  msg_limit,
  input  logic              underrun_clr,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              txd,
  output logic              msg_active,
  output logic              underrun_flag
);
  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [CRC_W-1:0]  crc;
  logic [CHAR_W-1:0] next_char;
  logic              boundary, at_limit, may_take, take, set_unr;
  logic              crc_start, crc_step;

  csync_shift #(.CHAR_W(CHAR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .load_val(next_char), .boundary(boundary), .txd(txd)
  );

  assign crc_start = take && (state_q == ST_IDLE);
  assign crc_step  = take && (state_q == ST_DATA);

  csync_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .start(crc_start), .step(crc_step),
    .data(in_data), .crc(crc)
  );

  assign at_limit   = (msg_limit != '0) && (cnt_q == msg_limit);
  assign may_take   = (state_q == ST_IDLE) || ((state_q == ST_DATA) && !at_limit);
  assign in_ready   = boundary && may_take;
  assign take       = in_ready && in_valid;
  assign msg_active = (state_q == ST_DATA);

  // choice of the character that follows the one now on the line
  always_comb begin
    state_d   = ST_IDLE;
    next_char = syn1;
    set_unr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d   = ST_DATA;
          next_char = in_data;
        end
      end
      ST_DATA: begin
        if (in_valid && !at_limit) begin
          state_d   = ST_DATA;
          next_char = in_data;
        end else begin
          set_unr = !at_limit;
          if (fill_policy[1]) begin
            state_d   = ST_CRCH;
            next_char = rev_char(crc[CRC_W-1 -: CHAR_W]);
          end else if (fill_policy[0] && bisync_mode) begin
            state_d   = ST_SYN0;
            next_char = syn0;
          end
        end
      end
      ST_CRCH: begin
        state_d   = ST_CRCL;
        next_char = rev_char(crc[CHAR_W-1:0]);
      end
      ST_CRCL: begin
        if (fill_policy[0] && bisync_mode) begin
          state_d   = ST_SYN0;
          next_char = syn0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      underrun_flag <= 1'b0;
    end else begin
      if (boundary) state_q <= state_d;
      if (take) cnt_q <= (state_q == ST_IDLE) ? CNT_W'(1) : cnt_q + 1'b1;
      if (boundary && set_unr) underrun_flag <= 1'b1;
      else if (underrun_clr)   underrun_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/csync_tx_chk.sv
module csync_tx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic [CNT_W-1:0] msg_limit,
  input logic             underrun_clr,
  input logic             in_valid,
  input logic             in_ready,
  input logic             txd,
  input logic             msg_active,
  input logic             underrun_flag
);
  logic [2:0]       phase_q;
  logic [CNT_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 3'd7;
      acc_q   <= '0;
    end else begin
      if (bit_en) phase_q <= phase_q + 3'd1;
      if (in_valid && in_ready) acc_q <= msg_active ? acc_q + 1'b1 : CNT_W'(1);
    end
  end

  // R2
  ready_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && phase_q == 3'd7));

  // R1
  txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd));

  // R4
  limit_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && msg_active && msg_limit != '0) |-> (acc_q < msg_limit));

  // R10
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_flag) |-> $past(msg_active && bit_en && !in_valid));

  // R10
  underrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_clr && !msg_active) |=> !underrun_flag);

  // R11
  active_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> msg_active);
endmodule

bind csync_tx csync_tx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .msg_limit(msg_limit),
  .underrun_clr(underrun_clr), .in_valid(in_valid), .in_ready(in_ready),
  .txd(txd), .msg_active(msg_active), .underrun_flag(underrun_flag)
);

// File: tb/tb_csync_tx.sv
`timescale 1ns/1ps
module tb_csync_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        bisync_mode = 1'b0;
  logic [1:0]  fill_policy = 2'b00;
  logic [7:0]  syn0 = 8'hC5;
  logic [7:0]  syn1 = 8'h2B;
  logic [15:0] msg_limit = '0;
  logic        underrun_clr = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, txd, msg_active, underrun_flag;

  always #4 clk = ~clk;

  csync_tx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bisync_mode(bisync_mode),
    .fill_policy(fill_policy), .syn0(syn0), .syn1(syn1), .msg_limit(msg_limit),
    .underrun_clr(underrun_clr), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .txd(txd), .msg_active(msg_active),
    .underrun_flag(underrun_flag)
  );

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  logic exp_b [0:1023];
  logic cap_b [0:1023];
  int   nexp, ncap;
  logic [7:0] dat [0:7];

  task automatic check(input logic ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic push_char(input logic [7:0] c);
    for (int i = 0; i < 8; i++) begin exp_b[nexp] = c[i]; nexp++; end
  endtask

  task automatic push_crc(input logic [15:0] c);
    for (int i = 15; i >= 0; i--) begin exp_b[nexp] = c[i]; nexp++; end
  endtask

  // R5 R6 R7 R8 fill sequences
  task automatic push_fill(input logic bis, input logic [1:0] pol, input logic [15:0] c);
    if (pol[1]) push_crc(c);
    if (pol[0] && bis) push_char(syn0);
    push_char(syn1);
  endtask

  task automatic run_case(input logic bis, input logic [1:0] pol, input int n,
                          input int lim, input logic lead, input int gap);
    int pos, k, idx, cyc_i;
    logic [15:0] c;
    logic flag_exp, hs, ben_prev, act_mid;
    string tag;
    tag = $sformatf("R%0d R3 R4 bis=%0d pol=%0d n=%0d lim=%0d", 5 + pol, bis, pol, n, lim);
    for (int i = 0; i < 8; i++) dat[i] = 8'(8'h5A + i * 8'h3B + pol * 8'h11 + bis * 8'h07);
    nexp = 0; pos = 0; flag_exp = 1'b0;
    if (lead) push_char(syn1);
    while (pos < n) begin
      c = 16'hFFFF; k = 0;
      while (pos < n && (lim == 0 || k < lim)) begin
        push_char(dat[pos]); c = ref_crc(c, dat[pos]); pos++; k++;
      end
      push_fill(bis, pol, c);
      if (lim == 0 || k < lim) flag_exp = 1'b1;
    end
    push_char(syn1); push_char(syn1);

    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; in_valid = 1'b0;
    bisync_mode = bis; fill_policy = pol; msg_limit = 16'(lim);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1 R10 R11 reset state
    check(txd === 1'b1 && underrun_flag === 1'b0 && msg_active === 1'b0,
          "R1 R10 R11 reset state", {txd, underrun_flag, msg_active}, 3'b100);

    idx = 0; ncap = 0; hs = 1'b0; ben_prev = 1'b0; cyc_i = 0; act_mid = 1'b0;
    while (ncap < nexp && cyc_i < 8000) begin
      @(negedge clk);
      if (ben_prev) begin
        cap_b[ncap] = txd;
        if (ncap == 4) act_mid = msg_active;
        ncap++;
      end
      if (hs) idx++;
      bit_en   = ((cyc_i % gap) == 0);
      in_valid = (idx < n) && !(lead && ncap < 8);
      in_data  = dat[idx[2:0]];
      #1;
      hs = in_valid && in_ready;
      ben_prev = bit_en;
      cyc_i++;
    end
    @(negedge clk);
    bit_en = 1'b0; in_valid = 1'b0;

    check(ncap == nexp, {"R1 stream length ", tag}, ncap, nexp);
    begin
      int bad = -1;
      for (int i = 0; i < nexp; i++) if (bad < 0 && cap_b[i] !== exp_b[i]) bad = i;
      check(bad < 0, {"R1 R9 serial stream ", tag}, bad < 0 ? 0 : int'(cap_b[bad]),
            bad < 0 ? 0 : int'(exp_b[bad]));
      if (bad >= 0) $display("  first mismatch at bit %0d", bad);
    end
    check(idx == n, {"R2 R4 bytes accepted ", tag}, idx, n);
    // R11 data character shifting vs idle sync lead-in
    check(act_mid === !lead, {"R11 msg_active mid char ", tag}, act_mid, !lead);
    check(msg_active === 1'b0, {"R11 msg_active idle ", tag}, msg_active, 0);
    // R10 sticky underrun, not set by a limit end
    check(underrun_flag === flag_exp, {"R10 underrun flag ", tag}, underrun_flag, flag_exp);
    underrun_clr = 1'b1;
    @(negedge clk);
    underrun_clr = 1'b0;
    check(underrun_flag === 1'b0, {"R10 flag cleared ", tag}, underrun_flag, 0);
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 4; p++) begin
        run_case(b[0], p[1:0], 3, 0, 1'b1, 1 + (p % 2) * 2);
        run_case(b[0], p[1:0], 5, 3, 1'b0, 3 - (p % 2) * 2);
        run_case(b[0], p[1:0], 4, 4, 1'b0, 1 + (p % 2) * 2);
      end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule